// File: doc/BRIEF.md
# Bridge System Error Reporting Unit

This unit collects error events from a two-sided bus bridge and turns them into one active-low system-error indication on the primary side. The events come in as one-cycle pulses. Six of them can be masked one by one. The seventh, the master-timeout event, has a separate enable instead of a mask bit. The unit also watches an already-synchronized secondary-side system-error line and can forward it to the primary side. A global enable must be set before anything is reported.

Every reported assertion does three things. It pulls the primary line low for one clock, it sets a sticky "signaled" status bit, and it sets a sticky reason bit for each event that caused it. A separate sticky "received" bit records that the secondary line was seen low. Software reads these bits over a small register port and clears them by writing ones.

Top module: `syserr_report`

## Requirements
- R1: After reset the drive output is 0, the status register (address 0) reads 0 and the reason register (address 1) reads 0.
- R2: While the global enable `cmd_serr_en_i` is 0, no event and no secondary assertion raises the drive output, and no reason bit is set.
- R3: A pulse on a maskable event bit i (bits 0 to 5) in cycle t, with the global enable set and mask bit i clear, makes the drive output 1 in cycle t+1 only.
- R4: A set mask bit i fully suppresses maskable event i: there is no drive and no reason bit i.
- R5: The master-timeout event (bit 6) raises the drive output only when `mto_en_i` is set. The mask input never affects it.
- R6: In the default edge mode, a high-to-low change seen on `sec_serr_n_i` raises the drive output for one cycle when both the global enable and `fwd_en_i` are set. Holding the line low causes no further assertion.
- R7: Any cycle in which `sec_serr_n_i` is sampled low sets status bit 1 ("received"), whatever the enables are.
- R8: Every drive assertion sets status bit 0 ("signaled") on the same clock edge.
- R9: Reason bit i (address 1, bit i) is set only when event i passed both the global enable and its own mask or enable.
- R10: Events that arrive in the same cycle produce a single one-cycle assertion and set every qualifying reason bit.
- R11: Writing 1 to a bit of the status or reason register clears it. Writing 0 leaves it unchanged. A set and a clear of the same bit in one cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_serr_en_i | input | 1 | Global enable for any system-error assertion |
| fwd_en_i | input | 1 | Enables forwarding of the secondary-side assertion |
| mto_en_i | input | 1 | Enable for the master-timeout event |
| evt_mask_i | input | N_EVT-1 | Per-event suppress bits for the maskable events |
| evt_i | input | N_EVT | One-cycle event pulses; the top bit is master timeout |
| sec_serr_n_i | input | 1 | Synchronized secondary system-error line, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address: 0 status, 1 reason |
| wr_data_i | input | DATA_W | Write data, ones clear the matching bits |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Combinational read data; other addresses read 0 |
| serr_drive_o | output | 1 | 1 pulls the primary system-error line low; 0 releases it |

## Verification
The assertions assume that `sec_serr_n_i` has already been synchronized to `clk`. They also assume that the configuration inputs and the write port change only between clock edges, so every sampled value belongs to a single cycle. The bench drives all inputs on the falling edge. Each event is held for exactly one rising edge and then returned to zero. Configuration changes happen only between steps, so each cause checked by the assertions lines up with the cycle in which it was sampled.

// File: rtl/syserr_pkg.sv
package syserr_pkg;
   localparam int unsigned REG_STATUS  = 0;
   localparam int unsigned REG_REASON  = 1;
   localparam int unsigned STAT_SIG    = 0;
   localparam int unsigned STAT_RCV    = 1;
   localparam int unsigned STAT_W      = 2;

   typedef enum logic {
      SEC_LEVEL = 1'b0,
      SEC_EDGE  = 1'b1
   } sec_mode_e;
endpackage

// File: rtl/syserr_qualify.sv
module syserr_qualify #(
   parameter int unsigned N_EVT = 7
) (
   input  logic [N_EVT-1:0] evt_i,
   input  logic [N_EVT-2:0] mask_i,
   input  logic             cmd_en_i,
   input  logic             mto_en_i,
   input  logic             fwd_en_i,
   input  logic             sec_hit_i,
   output logic [N_EVT-1:0] fire_o,
   output logic             assert_o
);
   localparam int unsigned N_MASKABLE = N_EVT - 1;

   logic [N_EVT-1:0] allow;

   // maskable events: allowed when the suppress bit is clear
   for (genvar g = 0; g < N_MASKABLE; g++) begin : g_mask
      assign allow[g] = ~mask_i[g];
   end
   // master timeout: allowed only through its own enable
   assign allow[N_EVT-1] = mto_en_i;

   assign fire_o   = evt_i & allow & {N_EVT{cmd_en_i}};
   assign assert_o = (|fire_o) | (cmd_en_i & fwd_en_i & sec_hit_i);
endmodule

// File: rtl/syserr_sec_detect.sv
module syserr_sec_detect #(
   parameter syserr_pkg::sec_mode_e MODE = syserr_pkg::SEC_EDGE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_n_i,
   output logic hit_o,
   output logic low_o
);
   assign low_o = ~sec_n_i;

   if (MODE == syserr_pkg::SEC_EDGE) begin : g_edge
      logic prev_n_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_n_q <= 1'b1;
         else        prev_n_q <= sec_n_i;
      end
      assign hit_o = prev_n_q & ~sec_n_i;
   end else begin : g_level
      logic unused_clkrst;
      assign unused_clkrst = clk ^ rst_n;
      assign hit_o = ~sec_n_i;
   end
endmodule

// File: rtl/syserr_w1c_bank.sv
module syserr_w1c_bank #(
   parameter int unsigned WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] q_o
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q_o[b] <= 1'b0;
         else if (set_i[b]) q_o[b] <= 1'b1;
         else if (clr_i[b]) q_o[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/syserr_report.sv
module syserr_report #(
   parameter int unsigned          N_EVT    = 7,
   parameter int unsigned          ADDR_W   = 2,
   parameter int unsigned          DATA_W   = 8,
   parameter syserr_pkg::sec_mode_e SEC_MODE = syserr_pkg::SEC_EDGE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_serr_en_i,
   input  logic              fwd_en_i,
   input  logic              mto_en_i,
   input  logic [N_EVT-2:0]  evt_mask_i,
   input  logic [N_EVT-1:0]  evt_i,
   input  logic              sec_serr_n_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              serr_drive_o
);
   import syserr_pkg::*;

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
   localparam logic [ADDR_W-1:0] A_REASON = ADDR_W'(REG_REASON);

   if (N_EVT < 2) begin : g_bad_nevt
      $error("N_EVT must be at least 2");
   end
   if (DATA_W < N_EVT || DATA_W < STAT_W) begin : g_bad_dataw
      $error("DATA_W too narrow for the register fields");
   end
   if (ADDR_W < 1) begin : g_bad_addrw
      $error("ADDR_W must be at least 1");
   end

   logic             sec_hit;
   logic             sec_low;
   logic [N_EVT-1:0] fire;
   logic             raise;
   logic             drive_q;
   logic             wr_status;
   logic             wr_reason;
   logic [STAT_W-1:0] stat_set;
   logic [STAT_W-1:0] stat_clr;
   logic [STAT_W-1:0] stat_q;
   logic [N_EVT-1:0] rsn_clr;
   logic [N_EVT-1:0] rsn_q;
   logic             sig_q;
   logic             rcv_q;
   logic             unused_wr_hi;

   syserr_sec_detect #(.MODE(SEC_MODE)) u_sec (
      .clk     (clk),
      .rst_n   (rst_n),
      .sec_n_i (sec_serr_n_i),
      .hit_o   (sec_hit),
      .low_o   (sec_low)
   );

   syserr_qualify #(.N_EVT(N_EVT)) u_qual (
      .evt_i     (evt_i),
      .mask_i    (evt_mask_i),
      .cmd_en_i  (cmd_serr_en_i),
      .mto_en_i  (mto_en_i),
      .fwd_en_i  (fwd_en_i),
      .sec_hit_i (sec_hit),
      .fire_o    (fire),
      .assert_o  (raise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drive_q <= 1'b0;
      else        drive_q <= raise;
   end
   assign serr_drive_o = drive_q;

   assign wr_status = wr_en_i && (wr_addr_i == A_STATUS);
   assign wr_reason = wr_en_i && (wr_addr_i == A_REASON);

   always_comb begin
      stat_set           = '0;
      stat_set[STAT_SIG] = raise;
      stat_set[STAT_RCV] = sec_low;
   end
   assign stat_clr = wr_status ? wr_data_i[STAT_W-1:0] : '0;
   assign rsn_clr  = wr_reason ? wr_data_i[N_EVT-1:0]  : '0;
   assign unused_wr_hi = ^wr_data_i;

   syserr_w1c_bank #(.WIDTH(STAT_W)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (stat_set),
      .clr_i (stat_clr),
      .q_o   (stat_q)
   );

   syserr_w1c_bank #(.WIDTH(N_EVT)) u_rsn (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (fire),
      .clr_i (rsn_clr),
      .q_o   (rsn_q)
   );

   assign sig_q = stat_q[STAT_SIG];
   assign rcv_q = stat_q[STAT_RCV];

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == A_STATUS)      rd_data_o = DATA_W'(stat_q);
      else if (rd_addr_i == A_REASON) rd_data_o = DATA_W'(rsn_q);
   end
endmodule

// File: rtl/syserr_report_chk.sv
module syserr_report_chk #(
   parameter int unsigned N_EVT  = 7,
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_en,
   input logic              fwd_en,
   input logic              mto_en,
   input logic [N_EVT-2:0]  mask,
   input logic [N_EVT-1:0]  evt,
   input logic              sec_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              drive,
   input logic              sig,
   input logic              rcv,
   input logic [N_EVT-1:0]  reason
);
   localparam logic [ADDR_W-1:0] A_REASON = ADDR_W'(syserr_pkg::REG_REASON);

   // R2: no drive unless the global enable was set in the cause cycle
   a_r2_needs_global_en: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> $past(cmd_en));

   // R4, R5, R6: every drive has a permitted cause one cycle earlier
   a_r4_drive_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> ($past(|(evt[N_EVT-2:0] & ~mask)) || $past(evt[N_EVT-1] && mto_en)
                 || $past(fwd_en && !sec_n)));

   // R7: low secondary line leaves the received bit set
   a_r7_rcv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_n |=> rcv);

   // R8: a drive is always accompanied by the signaled bit
   a_r8_sig_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> sig);

   // R9: a newly set reason bit coincides with a drive
   a_r9_reason_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
      ((reason & ~$past(reason)) != '0) |-> drive);

   // R11: reason bits fall only after a write to the reason register
   a_r11_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(reason) & ~reason) != '0) |-> $past(wr_en && (wr_addr == A_REASON)));
endmodule

bind syserr_report syserr_report_chk #(.N_EVT(N_EVT), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cmd_en  (cmd_serr_en_i),
   .fwd_en  (fwd_en_i),
   .mto_en  (mto_en_i),
   .mask    (evt_mask_i),
   .evt     (evt_i),
   .sec_n   (sec_serr_n_i),
   .wr_en   (wr_en_i),
   .wr_addr (wr_addr_i),
   .drive   (serr_drive_o),
   .sig     (sig_q),
   .rcv     (rcv_q),
   .reason  (rsn_q)
);

// File: tb/syserr_report_bench.sv
`timescale 1ns/1ps
module syserr_report_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_en = 1'b0, fwd_en = 1'b0, mto_en = 1'b0;
   logic [5:0] mask = '0;
   logic [6:0] evt = '0;
   logic       sec_n = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       drive;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic  exp_q[$];
   string req_q[$];

   // reference model state
   logic       m_sig = 0, m_rcv = 0, m_prev = 1;
   logic [6:0] m_rsn = '0;

   always #5 clk = ~clk;

   syserr_report u_syserr_report (
      .clk(clk), .rst_n(rst_n), .cmd_serr_en_i(cmd_en), .fwd_en_i(fwd_en),
      .mto_en_i(mto_en), .evt_mask_i(mask), .evt_i(evt), .sec_serr_n_i(sec_n),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .serr_drive_o(drive)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: compares the drive output against queued expectations
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) chk(req_q.pop_front(), 32'(drive), 32'(exp_q.pop_front()));
   end

   // driver: one clock of stimulus with its modelled outcome
   task automatic step(input logic [6:0] ev, input logic sn, input logic we,
                       input logic [1:0] wa, input logic [7:0] wd, input string req);
      logic [6:0] allow, fire;
      logic       hit, exp_drive;
      @(negedge clk);
      evt = ev; sec_n = sn; wr_en = we; wr_addr = wa; wr_data = wd;
      allow = {mto_en, ~mask};
      fire  = ev & allow & {7{cmd_en}};
      hit   = m_prev && !sn;
      exp_drive = (|fire) || (cmd_en && fwd_en && hit);
      m_prev = sn;
      if (we && wa == 2'd0) begin
         if (wd[0]) m_sig = 0;
         if (wd[1]) m_rcv = 0;
      end
      if (we && wa == 2'd1) m_rsn = m_rsn & ~wd[6:0];
      if (exp_drive) m_sig = 1;
      if (!sn) m_rcv = 1;
      m_rsn = m_rsn | fire;
      exp_q.push_back(exp_drive);
      req_q.push_back(req);
      @(posedge clk); #1;
      evt = '0; wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input string req);
      logic [7:0] exp;
      rd_addr = a; #1;
      exp = (a == 2'd0) ? {6'b0, m_rcv, m_sig} : (a == 2'd1) ? {1'b0, m_rsn} : 8'h00;
      chk(req, 32'(rd_data), 32'(exp));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 drive", 32'(drive), 0);
      rd_chk(2'd0, "R1 status");
      rd_chk(2'd1, "R1 reason");

      // R2: global enable off
      step(7'h7F, 1'b1, 0, 0, 0, "R2 no drive when disabled");
      rd_chk(2'd1, "R2 reason stays clear");

      // R3: each maskable event alone, then idle
      cmd_en = 1'b1;
      for (int i = 0; i < 6; i++) begin
         step(7'(1 << i), 1'b1, 0, 0, 0, "R3 single event drive");
         step(7'h00, 1'b1, 0, 0, 0, "R3 one cycle only");
      end
      rd_chk(2'd1, "R9 reason bits 0-5");
      rd_chk(2'd0, "R8 signaled set");

      // R11: write zero no effect, then write ones clear
      step(7'h00, 1'b1, 1, 2'd1, 8'h00, "R11 write zero idle");
      rd_chk(2'd1, "R11 zero keeps reason");
      step(7'h00, 1'b1, 1, 2'd1, 8'h7F, "R11 write ones idle");
      rd_chk(2'd1, "R11 ones clear reason");
      step(7'h00, 1'b1, 1, 2'd0, 8'h03, "R11 clear status");
      rd_chk(2'd0, "R11 status cleared");

      // R4: masked event
      mask = 6'b000100;
      step(7'h04, 1'b1, 0, 0, 0, "R4 masked event no drive");
      rd_chk(2'd1, "R4 masked reason clear");

      // R5: master timeout
      mask = 6'h3F; mto_en = 1'b0;
      step(7'h40, 1'b1, 0, 0, 0, "R5 timeout without enable");
      mto_en = 1'b1;
      step(7'h40, 1'b1, 0, 0, 0, "R5 timeout with enable despite mask");
      rd_chk(2'd1, "R5 reason bit6");

      // R10: coincident events
      mask = 6'b000000;
      step(7'h00, 1'b1, 1, 2'd1, 8'h7F, "R10 setup clear");
      step(7'h45, 1'b1, 0, 0, 0, "R10 coincident single drive");
      step(7'h00, 1'b1, 0, 0, 0, "R10 drive one cycle");
      rd_chk(2'd1, "R10 all qualifying reasons");

      // R7 / R6: secondary line
      step(7'h00, 1'b1, 1, 2'd0, 8'h03, "R7 setup clear status");
      fwd_en = 1'b0;
      step(7'h00, 1'b0, 0, 0, 0, "R7 no forward when disabled");
      rd_chk(2'd0, "R7 received set");
      step(7'h00, 1'b1, 0, 0, 0, "R6 line released");
      fwd_en = 1'b1;
      step(7'h00, 1'b0, 0, 0, 0, "R6 forwarded edge");
      step(7'h00, 1'b0, 0, 0, 0, "R6 held low no repeat");
      step(7'h00, 1'b1, 0, 0, 0, "R6 release");
      rd_chk(2'd0, "R8 signaled after forward");

      // R11: set wins over clear in the same cycle
      step(7'h00, 1'b1, 1, 2'd1, 8'h7F, "R11 clear before race");
      step(7'h02, 1'b1, 1, 2'd1, 8'h02, "R11 set and clear same cycle");
      rd_chk(2'd1, "R11 set wins");
      step(7'h00, 1'b1, 1, 2'd0, 8'h02, "R11 clear received only");
      rd_chk(2'd0, "R11 received cleared signaled kept");

      repeat (3) @(posedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule